// File: doc/BRIEF.md
# Per-core inter-processor interrupt register bank

This block is the interrupt register file that one processor core owns for receiving inter-processor interrupts. Other agents post interrupt requests by writing a bit pattern to a set strobe, and the owning core acknowledges them by writing the same bits to a clear strobe. A pending-bit register records the requests and an enable register masks them. A bank of 32-bit mailbox words carries message payloads. Every access uses one 32-bit register port, and the block drives a single level-sensitive interrupt line to the core.

The interrupt line is not a continuous function of pending AND enable. A set write can only raise it, and only when the updated pending bits overlap the enable mask. A clear write can only lower it, and only when it leaves no pending bits while the enable mask is nonzero. An enable write just stores the mask. Software that changes the mask therefore has to follow the change with a set or clear write to bring the line up to date.

Top module: `ipi_bank`

## Requirements
- R1: Only address bits [7:2] select a register. Bits [1:0] and every bit above bit 7 are ignored, so address 0x0124 reaches the same word as 0x0024.
- R2: The pending register is at offset 0x00 and is read-only. A write to 0x00 leaves its value unchanged.
- R3: A write to the set strobe at 0x08 ORs the write data into the pending register. The line goes to 1 on the following clock edge if (new pending AND enable) is nonzero. Otherwise the line keeps its value.
- R4: A write to the clear strobe at 0x0C removes the written bits from the pending register. The line goes to 0 only if the new pending value is zero and enable is nonzero. Otherwise the line keeps its value.
- R5: The enable register at 0x04 stores the written value and reads it back. An enable write never changes the line.
- R6: Reads of the set and clear strobes always return zero.
- R7: Eight 32-bit mailbox words at offsets 0x20, 0x24, ..., 0x3C are readable and writable. The word index is (offset - 0x20) >> 2.
- R8: Writes to undefined offsets (0x10 to 0x1C and 0x40 to 0xFC) change no state, and reads of those offsets return zero.
- R9: While rst_n is low, the pending register, the enable register, every mailbox word and the line are all zero.
- R10: rd_data shows the addressed register in the same cycle as a read request (req_valid=1, req_write=0) and is zero otherwise. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; only bits [7:2] are used |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, combinational from address |
| irq | output | 1 | Level interrupt line to the owning core |

## Verification
The line logic is exercised with several patterns. A set whose bits fall outside the enable mask must leave the line low, and a set that overlaps the mask must raise it. A partial clear must keep the line high, while a full clear with a nonzero mask must lower it. An enable change made while bits are pending must not move the line in either direction. A full clear with a zero mask must leave the line stuck high, which separates the edge-style rule from a plain pending-AND-enable output. The remaining cases are address aliasing through ignored upper bits, writes to undefined and read-only offsets that are read back as unchanged, and a reset applied mid-run that clears the mailboxes.

// File: rtl/ipi_bank.sv
module ipi_bank #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int MBOX_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam logic [5:0] W_PEND = 6'd0;
  localparam logic [5:0] W_EN   = 6'd1;
  localparam logic [5:0] W_SET  = 6'd2;
  localparam logic [5:0] W_CLR  = 6'd3;
  localparam int         MB_LO  = 8;
  localparam int         MB_HI  = MB_LO + MBOX_N;

  logic [DATA_W-1:0] pend, en;
  logic [DATA_W-1:0] mbox [MBOX_N];

  logic [5:0] word;
  logic       wr, rd, set_wr, clr_wr, en_wr;
  logic [DATA_W-1:0] pend_set, pend_clr;

  assign word     = req_addr[7:2];
  assign wr       = req_valid & req_write;
  assign rd       = req_valid & ~req_write;
  assign set_wr   = wr && (word == W_SET);
  assign clr_wr   = wr && (word == W_CLR);
  assign en_wr    = wr && (word == W_EN);
  assign pend_set = pend | req_wdata;
  assign pend_clr = pend & ~req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      if (en_wr) en <= req_wdata;
      if (set_wr) begin
        pend <= pend_set;
        if ((pend_set & en) != '0) irq <= 1'b1;
      end else if (clr_wr) begin
        pend <= pend_clr;
        if (pend_clr == '0 && en != '0) irq <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < MBOX_N; g++) begin : g_mbox
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mbox[g] <= '0;
      else if (wr && word == 6'(MB_LO + g)) mbox[g] <= req_wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd) begin
      case (word)
        W_PEND: rd_data = pend;
        W_EN:   rd_data = en;
        default: begin
          for (int i = 0; i < MBOX_N; i++)
            if (word == 6'(MB_LO + i)) rd_data = mbox[i];
        end
      endcase
    end
  end

  AST_PEND_NO_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == W_PEND) |=> (pend == $past(pend))); // R2

  AST_PEND_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != '0) |-> $past(set_wr)); // R3

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && ((pend | req_wdata) & en) != '0) |=> irq); // R3

  AST_RISE_ONLY_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_wr)); // R3

  AST_CLEAR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (pend & ~req_wdata) == '0 && en != '0) |=> !irq); // R4

  AST_FALL_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_wr)); // R4

  AST_EN_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> $stable(irq)); // R5

  AST_STROBES_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (word == W_SET || word == W_CLR)) |-> (rd_data == '0)); // R6

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rd_data == '0)); // R10

  AST_RESET_LINE_LOW: assert property (@(posedge clk)
    !rst_n |-> !irq); // R9

endmodule

// File: tb/ipi_bank_bench.sv
module ipi_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ipi_bank u_ipi_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .irq(irq)
  );

  // {req_id[3:0], write, addr[15:0], data[31:0] (write data or expected read), expected irq}
  localparam int NV = 31;
  localparam logic [53:0] VEC [NV] = '{
    {4'd5, 1'b1, 16'h0004, 32'h0000_00F0, 1'b0}, // R5 enable write
    {4'd5, 1'b0, 16'h0004, 32'h0000_00F0, 1'b0}, // R5 read back
    {4'd3, 1'b1, 16'h0008, 32'h0000_0003, 1'b0}, // R3 set outside mask
    {4'd3, 1'b0, 16'h0000, 32'h0000_0003, 1'b0}, // R3 pending ORed
    {4'd3, 1'b1, 16'h0008, 32'h0000_0010, 1'b1}, // R3 set inside mask raises
    {4'd3, 1'b0, 16'h0000, 32'h0000_0013, 1'b1}, // R3
    {4'd4, 1'b1, 16'h000C, 32'h0000_0010, 1'b1}, // R4 partial clear keeps line
    {4'd4, 1'b0, 16'h0000, 32'h0000_0003, 1'b1}, // R4
    {4'd2, 1'b1, 16'h0000, 32'hFFFF_FFFF, 1'b1}, // R2 write to read-only
    {4'd2, 1'b0, 16'h0000, 32'h0000_0003, 1'b1}, // R2 unchanged
    {4'd6, 1'b0, 16'h0008, 32'h0000_0000, 1'b1}, // R6 set reads zero
    {4'd6, 1'b0, 16'h000C, 32'h0000_0000, 1'b1}, // R6 clear reads zero
    {4'd4, 1'b1, 16'h000C, 32'h0000_0003, 1'b0}, // R4 full clear lowers
    {4'd7, 1'b1, 16'h0020, 32'hA5A5_0001, 1'b0}, // R7 first word
    {4'd7, 1'b1, 16'h003C, 32'h5A5A_0008, 1'b0}, // R7 last word
    {4'd7, 1'b0, 16'h0020, 32'hA5A5_0001, 1'b0}, // R7
    {4'd7, 1'b0, 16'h003C, 32'h5A5A_0008, 1'b0}, // R7
    {4'd1, 1'b1, 16'h0124, 32'h1234_5678, 1'b0}, // R1 aliased write
    {4'd1, 1'b0, 16'h0024, 32'h1234_5678, 1'b0}, // R1
    {4'd1, 1'b0, 16'h0104, 32'h0000_00F0, 1'b0}, // R1 aliased read
    {4'd8, 1'b1, 16'h0010, 32'h0000_DEAD, 1'b0}, // R8 hole write
    {4'd8, 1'b0, 16'h0010, 32'h0000_0000, 1'b0}, // R8 hole reads zero
    {4'd8, 1'b1, 16'h0040, 32'h0000_BEEF, 1'b0}, // R8 past mailboxes
    {4'd8, 1'b0, 16'h0040, 32'h0000_0000, 1'b0}, // R8
    {4'd5, 1'b1, 16'h0004, 32'h0000_0000, 1'b0}, // R5 mask off
    {4'd3, 1'b1, 16'h0008, 32'h0000_0001, 1'b0}, // R3 set with zero mask
    {4'd5, 1'b1, 16'h0004, 32'h0000_0001, 1'b0}, // R5 enable does not raise
    {4'd3, 1'b1, 16'h0008, 32'h0000_0000, 1'b1}, // R3 empty set re-evaluates
    {4'd5, 1'b1, 16'h0004, 32'h0000_0000, 1'b1}, // R5 enable does not lower
    {4'd4, 1'b1, 16'h000C, 32'h0000_0001, 1'b1}, // R4 clear with zero mask keeps line
    {4'd4, 1'b0, 16'h0000, 32'h0000_0000, 1'b1}  // R4 pending now empty
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 check(tag, rd_data, exp);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 irq in reset", {31'b0, irq}, 32'h0);
    check("R10 idle rd_data", rd_data, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_write = VEC[i][49];
      req_addr  = VEC[i][48:33];
      req_wdata = VEC[i][32:1];
      if (!VEC[i][49]) begin
        #1 check($sformatf("R%0d/R10 read vec %0d", VEC[i][53:50], i), rd_data, VEC[i][32:1]);
      end
      @(posedge clk);
      #1 check($sformatf("R%0d irq vec %0d", VEC[i][53:50], i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end
    @(negedge clk);
    req_valid = 1'b0;

    rd_chk("R8 mailbox 0 after hole writes", 16'h0020, 32'hA5A5_0001);
    rd_chk("R8 mailbox 7 after hole writes", 16'h003C, 32'h5A5A_0008);

    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R9 irq low in reset", {31'b0, irq}, 32'h0);
    rd_chk("R9 mailbox cleared", 16'h0020, 32'h0);
    rd_chk("R9 mailbox 1 cleared", 16'h0024, 32'h0);
    rd_chk("R9 enable cleared", 16'h0004, 32'h0);
    rd_chk("R9 pending cleared", 16'h0000, 32'h0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule